// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block holds the pending and enable bits for 256 general-purpose events. It sits inside a power-management register window. Software reaches it through a simple register bus that only accepts single-byte accesses. Hardware reports events through a separate port that carries an event index. Each index sets one pending bit.

The block raises a system control interrupt whenever an event is both pending and enabled. Software acknowledges an event by writing ones to its pending bits. The block gives two interrupt outputs:
- a level that follows the condition on every cycle;
- a one-cycle pulse at each point where the condition is evaluated (an event arrival or an enable write) and is found true.

The register block starts at byte offset 8 of the window. That is behind a 4-byte event block and 4 bytes of padding, which keeps it 32-bit aligned. With `NUM_EVT` events there are `NUM_EVT/8` pending bytes, followed directly by the same number of enable bytes.

Top module: `gpe0_blk`

## Requirements
- R1: After reset every pending and enable byte reads 0x00, and both `sci_level` and `sci_pulse` are low.
- R2: A read with `bus_len` = 1 at window offset 8+i returns pending byte i. A read at offset 8+NUM_EVT/8+i returns enable byte i. The data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R3: A one-byte write to a pending byte clears each bit written as 1 and keeps each bit written as 0.
- R4: A one-byte write to an enable byte replaces that byte with the written value.
- R5: An accepted event with index n sets bit n%8 of pending byte n/8, and leaves the other bits unchanged.
- R6: An event index of NUM_EVT or above changes no state. It pulses `evt_err` for one cycle, in the cycle after it arrives, and does not produce `sci_pulse`.
- R7: An access inside the block with `bus_len` other than 1 changes no state and gives no `bus_rvalid`. It pulses `bus_err` in the cycle after the request.
- R8: `sci_level` is high exactly when some pending byte ANDed with its enable byte is nonzero. It reflects the state that results from each cycle's update.
- R9: `sci_pulse` is high for one cycle after an accepted event or enable write exactly when the updated condition of R8 is true. It stays low after every other kind of cycle.
- R10: When an event sets a pending bit in the same cycle as a write that clears that bit, the bit ends up set.
- R11: An access to a window offset outside the block changes no state and gives neither `bus_rvalid` nor `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the power-management window |
| bus_len | input | LEN_W | Access width in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| bus_rdata | output | 8 | Read data |
| bus_err | output | 1 | Rejected access width, one cycle after the request |
| evt_valid | input | 1 | Event index valid |
| evt_num | input | $clog2(NUM_EVT)+1 | Event index |
| evt_err | output | 1 | Event index out of range, one cycle after arrival |
| sci_level | output | 1 | Interrupt condition level |
| sci_pulse | output | 1 | Interrupt pulse at a true evaluation point |

## Verification
The bench builds the block with its default parameters: 256 events, an 8-bit window offset and a 3-bit width field. With those values the event index runs from 0 to 511, so every out-of-range index up to twice the event count can be driven. The offsets run from 0 to 255, so the reads and writes can fall before the block, across the boundary between the pending and enable halves, and past the end of the block. Both edges of the event space (indices 0, 255 and 256) are reached directly. Random traffic then mixes events, clears and enable rewrites so that the interrupt level rises and falls many times.

// File: rtl/gpe0_pkg.sv
package gpe0_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STS  = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpe0_addr_dec.sv
module gpe0_addr_dec
    import gpe0_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned LEN_W     = 3,
    parameter int unsigned BLK_BASE  = 8,
    parameter int unsigned NUM_BYTES = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx,
    output logic              len_ok
);
    localparam int unsigned SPAN = 2 * NUM_BYTES;

    int unsigned a_u;
    int unsigned rel;
    logic        in_blk;

    assign a_u    = 32'(addr);
    assign in_blk = (a_u >= BLK_BASE) && (a_u < BLK_BASE + SPAN);
    assign rel    = a_u - BLK_BASE;
    assign len_ok = (len == LEN_W'(1));

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (in_blk) begin
            if (rel < NUM_BYTES) begin
                sel = SEL_STS;
                idx = IDX_W'(rel);
            end else begin
                sel = SEL_EN;
                idx = IDX_W'(rel - NUM_BYTES);
            end
        end
    end
endmodule

// File: rtl/gpe0_evt_dec.sv
module gpe0_evt_dec #(
    parameter int unsigned NUM_EVT   = 256,
    parameter int unsigned NUM_BYTES = 32,
    parameter int unsigned EVT_W     = 9
) (
    input  logic                        valid,
    input  logic [EVT_W-1:0]            num,
    output logic                        hit,
    output logic [NUM_BYTES-1:0][7:0]   set_mask
);
    localparam int unsigned HI_W = EVT_W - 3;

    assign hit = (32'(num) < NUM_EVT);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign set_mask[b] = (valid && hit && (num[EVT_W-1:3] == HI_W'(b)))
                             ? (8'h01 << num[2:0]) : 8'h00;
    end
endmodule

// File: rtl/gpe0_sci_eval.sv
module gpe0_sci_eval #(
    parameter int unsigned NUM_BYTES = 32
) (
    input  logic [NUM_BYTES-1:0][7:0] sts,
    input  logic [NUM_BYTES-1:0][7:0] en,
    output logic                      any
);
    logic [NUM_BYTES-1:0] byte_hit;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_and
        assign byte_hit[b] = |(sts[b] & en[b]);
    end

    assign any = |byte_hit;
endmodule

// File: rtl/gpe0_blk.sv
module gpe0_blk
    import gpe0_pkg::*;
#(
    parameter int unsigned NUM_EVT  = 256,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned LEN_W    = 3,
    parameter int unsigned BLK_BASE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [LEN_W-1:0]           bus_len,
    input  logic [7:0]                 bus_wdata,
    output logic                       bus_rvalid,
    output logic [7:0]                 bus_rdata,
    output logic                       bus_err,
    input  logic                       evt_valid,
    input  logic [$clog2(NUM_EVT):0]   evt_num,
    output logic                       evt_err,
    output logic                       sci_level,
    output logic                       sci_pulse
);
    localparam int unsigned NUM_BYTES = NUM_EVT / 8;
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES);
    localparam int unsigned EVT_W     = $clog2(NUM_EVT) + 1;

    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] sts;
        logic [NUM_BYTES-1:0][7:0] en;
        logic [7:0]                rdata;
        logic                      rvalid;
        logic                      berr;
        logic                      everr;
        logic                      lvl;
        logic                      pls;
    } state_t;

    state_t s_d, s_q;

    reg_sel_e                  sel;
    logic [IDX_W-1:0]          idx;
    logic                      len_ok;
    logic                      evt_hit;
    logic [NUM_BYTES-1:0][7:0] set_mask;
    logic [NUM_BYTES-1:0][7:0] sts_nx;
    logic [NUM_BYTES-1:0][7:0] en_nx;
    logic                      any_nx;
    logic                      wr_ok;
    logic                      rd_ok;

    gpe0_addr_dec #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BASE(BLK_BASE),
        .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
    ) u_addr_dec (
        .addr(bus_addr), .len(bus_len), .sel(sel), .idx(idx), .len_ok(len_ok)
    );

    gpe0_evt_dec #(
        .NUM_EVT(NUM_EVT), .NUM_BYTES(NUM_BYTES), .EVT_W(EVT_W)
    ) u_evt_dec (
        .valid(evt_valid), .num(evt_num), .hit(evt_hit), .set_mask(set_mask)
    );

    assign wr_ok = bus_req && bus_wr  && (sel != SEL_NONE) && len_ok;
    assign rd_ok = bus_req && !bus_wr && (sel != SEL_NONE) && len_ok;

    // Array update: clear first, then set, so a same-cycle event wins.
    always_comb begin
        for (int b = 0; b < NUM_BYTES; b++) begin
            sts_nx[b] = s_q.sts[b];
            en_nx[b]  = s_q.en[b];
            if (wr_ok && (idx == IDX_W'(b))) begin
                if (sel == SEL_STS) sts_nx[b] = sts_nx[b] & ~bus_wdata;
                if (sel == SEL_EN)  en_nx[b]  = bus_wdata;
            end
            sts_nx[b] = sts_nx[b] | set_mask[b];
        end
    end

    gpe0_sci_eval #(
        .NUM_BYTES(NUM_BYTES)
    ) u_sci_eval (
        .sts(sts_nx), .en(en_nx), .any(any_nx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.sts    = sts_nx;
        s_d.en     = en_nx;
        s_d.rvalid = rd_ok;
        s_d.rdata  = '0;
        if (rd_ok) begin
            s_d.rdata = (sel == SEL_EN) ? s_q.en[idx] : s_q.sts[idx];
        end
        s_d.berr   = bus_req && (sel != SEL_NONE) && !len_ok;
        s_d.everr  = evt_valid && !evt_hit;
        s_d.lvl    = any_nx;
        s_d.pls    = any_nx && ((evt_valid && evt_hit) || (wr_ok && (sel == SEL_EN)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rvalid = s_q.rvalid;
    assign bus_rdata  = s_q.rdata;
    assign bus_err    = s_q.berr;
    assign evt_err    = s_q.everr;
    assign sci_level  = s_q.lvl;
    assign sci_pulse  = s_q.pls;

    logic [NUM_EVT-1:0] sts_flat;
    logic [NUM_EVT-1:0] en_flat;
    assign sts_flat = s_q.sts;
    assign en_flat  = s_q.en;
endmodule

// File: rtl/gpe0_blk_chk.sv
module gpe0_blk_chk #(
    parameter int unsigned NBITS = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_wr,
    input logic             evt_valid,
    input logic             bus_rvalid,
    input logic             bus_err,
    input logic             evt_err,
    input logic             sci_level,
    input logic             sci_pulse,
    input logic [NBITS-1:0] sts,
    input logic [NBITS-1:0] en
);
    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_wr));

    // R7
    err_excludes_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!bus_rvalid && $past(bus_req)));

    // R6
    evt_err_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> $past(evt_valid));

    // R8
    level_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_level == ((sts & en) != '0));

    // R9
    pulse_implies_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pulse |-> (sci_level && $past(evt_valid || (bus_req && bus_wr))));

    // R5
    sts_rise_from_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts)) != '0) |-> $past(evt_valid));

    // R4
    en_change_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en)) |-> $past(bus_req && bus_wr));

    // R3
    sts_fall_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts) & ~sts) != '0) |-> $past(bus_req && bus_wr));
endmodule

bind gpe0_blk gpe0_blk_chk #(.NBITS(NUM_EVT)) u_gpe0_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .evt_valid(evt_valid), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .evt_err(evt_err), .sci_level(sci_level), .sci_pulse(sci_pulse),
    .sts(sts_flat), .en(en_flat)
);

// File: tb/gpe0_blk_bench.sv
`timescale 1ns/1ps
module gpe0_blk_bench;
    localparam int NEVT  = 256;
    localparam int NB    = NEVT / 8;
    localparam int BASE  = 8;
    localparam int EVW   = 9;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bus_req, bus_wr;
    logic [7:0]     bus_addr;
    logic [2:0]     bus_len;
    logic [7:0]     bus_wdata;
    logic           bus_rvalid, bus_err;
    logic [7:0]     bus_rdata;
    logic           evt_valid;
    logic [EVW-1:0] evt_num;
    logic           evt_err, sci_level, sci_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_sts [NB];
    logic [7:0] m_en  [NB];

    always #4 clk = ~clk;

    gpe0_blk u_gpe0_blk (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_valid(evt_valid), .evt_num(evt_num), .evt_err(evt_err),
        .sci_level(sci_level), .sci_pulse(sci_pulse)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cond_now();
        for (int b = 0; b < NB; b++) if ((m_sts[b] & m_en[b]) != 8'h00) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle of stimulus, then checks of every output against the model.
    task automatic step(input string tag, input bit rq, input bit wr, input int a,
                        input int ln, input int wd, input bit ev, input int num);
        bit inb, hi, ok, exp_rv, exp_be, evok, exp_ee, eval;
        int ix;
        logic [7:0] exp_rd;
        bus_req = rq; bus_wr = wr; bus_addr = 8'(a); bus_len = 3'(ln);
        bus_wdata = 8'(wd); evt_valid = ev; evt_num = EVW'(num);
        inb = (a >= BASE) && (a < BASE + 2*NB);
        hi  = (a >= BASE + NB);
        ix  = inb ? (hi ? a - BASE - NB : a - BASE) : 0;
        ok  = inb && (ln == 1);
        exp_rv = rq && !wr && ok;
        exp_rd = exp_rv ? (hi ? m_en[ix] : m_sts[ix]) : 8'h00;
        exp_be = rq && inb && (ln != 1);
        evok   = ev && (num < NEVT);
        exp_ee = ev && !evok;
        if (rq && wr && ok) begin
            if (hi) m_en[ix]  = 8'(wd);
            else    m_sts[ix] = m_sts[ix] & ~8'(wd);
        end
        if (evok) m_sts[num / 8] = m_sts[num / 8] | (8'h01 << (num % 8));
        eval = evok || (rq && wr && ok && hi);
        @(negedge clk);
        chk(tag, "rvalid", int'(bus_rvalid), int'(exp_rv));
        if (exp_rv) chk(tag, "rdata", int'(bus_rdata), int'(exp_rd));
        chk(tag, "bus_err", int'(bus_err), int'(exp_be));
        chk("R6", "evt_err", int'(evt_err), int'(exp_ee));
        chk("R8", "sci_level", int'(sci_level), int'(cond_now()));
        chk("R9", "sci_pulse", int'(sci_pulse), int'(eval && cond_now()));
    endtask

    task automatic rd(input string tag, input int a);
        step(tag, 1'b1, 1'b0, a, 1, 0, 1'b0, 0);
    endtask

    task automatic idle();
        step("R2", 1'b0, 1'b0, 0, 1, 0, 1'b0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1789));
        for (int b = 0; b < NB; b++) begin m_sts[b] = 8'h00; m_en[b] = 8'h00; end
        rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_len = 3'd1;
        bus_wdata = '0; evt_valid = 1'b0; evt_num = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "sci_level", int'(sci_level), 0);
        chk("R1", "sci_pulse", int'(sci_pulse), 0);
        for (int a = BASE; a < BASE + 2*NB; a++) rd("R1", a);

        // R5: event edges of the space
        step("R5", 1'b0, 1'b0, 0, 1, 0, 1'b1, 0);
        step("R5", 1'b0, 1'b0, 0, 1, 0, 1'b1, 7);
        step("R5", 1'b0, 1'b0, 0, 1, 0, 1'b1, 8);
        step("R5", 1'b0, 1'b0, 0, 1, 0, 1'b1, 255);
        rd("R5", BASE); rd("R5", BASE + 1); rd("R5", BASE + NB - 1);

        // R4 and R9: enable write with pending bit gives a pulse
        step("R4", 1'b1, 1'b1, BASE + NB, 1, 8'h01, 1'b0, 0);
        rd("R4", BASE + NB);
        step("R4", 1'b1, 1'b1, BASE + NB, 1, 8'h00, 1'b0, 0);
        step("R4", 1'b1, 1'b1, BASE + 2*NB - 1, 1, 8'h80, 1'b0, 0);

        // R3: write-one-to-clear, partial mask
        step("R3", 1'b1, 1'b1, BASE, 1, 8'h80, 1'b0, 0);
        rd("R3", BASE);
        step("R3", 1'b1, 1'b1, BASE + NB - 1, 1, 8'h80, 1'b0, 0);
        rd("R3", BASE + NB - 1);

        // R6: out-of-range event indices
        step("R6", 1'b0, 1'b0, 0, 1, 0, 1'b1, 256);
        step("R6", 1'b0, 1'b0, 0, 1, 0, 1'b1, 511);
        for (int a = BASE; a < BASE + NB; a++) rd("R6", a);

        // R7: bad access widths
        step("R7", 1'b1, 1'b1, BASE + NB + 2, 2, 8'hff, 1'b0, 0);
        step("R7", 1'b1, 1'b0, BASE + 3, 0, 0, 1'b0, 0);
        step("R7", 1'b1, 1'b1, BASE + 1, 4, 8'hff, 1'b0, 0);
        rd("R7", BASE + NB + 2); rd("R7", BASE + 1);

        // R10: set and clear of the same bit in one cycle
        step("R10", 1'b1, 1'b1, BASE + 5, 1, 8'h01, 1'b1, 40);
        rd("R10", BASE + 5);

        // R11: outside the block
        step("R11", 1'b1, 1'b0, 0, 1, 0, 1'b0, 0);
        step("R11", 1'b1, 1'b0, BASE - 1, 1, 0, 1'b0, 0);
        step("R11", 1'b1, 1'b1, BASE + 2*NB, 1, 8'hff, 1'b0, 0);
        step("R11", 1'b1, 1'b1, 200, 2, 8'hff, 1'b0, 0);
        rd("R11", BASE + 2*NB);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            step("R2", ($urandom_range(0, 3) != 0), ($urandom_range(0, 1) == 1),
                 int'($urandom_range(2, 77)), ($urandom_range(0, 9) == 0) ? 2 : 1,
                 int'($urandom_range(0, 255)), ($urandom_range(0, 2) == 0),
                 int'($urandom_range(0, 290)));
        end
        for (int a = BASE; a < BASE + 2*NB; a++) rd("R2", a);
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule